// File: doc/BRIEF.md
# Round-Robin Arbiter with Merged Data Selection

This block picks one of `NUM_REQ` requesters in round-robin order and, in the same combinational pass, forwards the winner's data word to its output. Each position turns its request bit and its priority bit into a 2-bit thermometer symbol: `00` for idle, `01` for an active request without priority, and `11` for an active request with priority. A binary tree of maximum nodes then reduces these symbols. At each node a direction flag chooses the larger symbol, and ties go to the lower-numbered (right) side. The same flag steers that node's 2:1 data selector and supplies one bit of the winner's binary index. Because the priority vector is thermometer coded, the cyclic search becomes a plain maximum search with no wrap-around path.

The only stored state is the priority vector `prio_q`. It has one bit per position, and its ones run from the highest-priority position up to position `NUM_REQ-1`. The vector has two named conditions:

- **HOLD**: the vector keeps its value when `upd_en` is low or when no grant is made.
- **ADVANCE**: the vector is rewritten to rotate priority past the winner when `upd_en` is high and a grant is made.

A switch output port drives `upd_en` whenever the granted transfer is really consumed.

Top module: `rrmx_top`

## Requirements
- R1: `any_grant` is 1 exactly when at least one bit of `req` is 1.
- R2: `gnt_oh` has at most one bit set. That bit always belongs to a position whose `req` bit is 1, and `gnt_oh` is all zeros when no request is active.
- R3: When `any_grant` is 1, `gnt_idx` is the binary number of the position set in `gnt_oh`. When `any_grant` is 0, `gnt_idx` is 0.
- R4: `data_out` equals the data word of the granted position, where word i occupies bits `[i*DATA_W +: DATA_W]` of `data_in`. `data_out` is all zeros when no grant is made.
- R5: The granted position is the first active request found by scanning upward from the current highest-priority position and wrapping from `NUM_REQ-1` to 0.
- R6: After reset, position 0 has the highest priority (the priority vector is all ones).
- R7: On a rising clock edge where `upd_en` and `any_grant` are both 1, the highest priority moves to the position one above the winner. When the winner is `NUM_REQ-1`, it wraps to position 0.
- R8: On a rising clock edge where `upd_en` is 0 or no request is active, the priority order is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_REQ | Request vector, bit i for position i |
| data_in | input | NUM_REQ*DATA_W | Packed data words, word i at `[i*DATA_W +: DATA_W]` |
| upd_en | input | 1 | Allows the priority vector to advance past this cycle's winner |
| data_out | output | DATA_W | Data word of the granted position |
| any_grant | output | 1 | A request was granted this cycle |
| gnt_oh | output | NUM_REQ | One-hot grant |
| gnt_idx | output | $clog2(NUM_REQ) | Binary index of the granted position |

## Verification
A wrong priority vector is invisible while only one requester is active. It shows up in `gnt_oh`, `gnt_idx` and `data_out` in the first cycle in which two or more requesters compete. The bench therefore keeps all-ones request patterns and dense random patterns running, so that the error appears within a cycle or two. A defect in the update rule, such as a missed wrap or an advance without `upd_en`, moves the expected winner on the very next cycle. The cycle-by-cycle pointer model catches it on the following comparison. A tie-breaking or steering fault in a tree node shows up as soon as requests on both sides of that node compete.

// File: rtl/rrmx_pkg.sv
package rrmx_pkg;

    typedef logic [1:0] rr_sym_t;

    localparam rr_sym_t SYM_IDLE = 2'b00;
    localparam rr_sym_t SYM_LOW  = 2'b01;
    localparam rr_sym_t SYM_HIGH = 2'b11;

    function automatic rr_sym_t make_sym(input logic active, input logic prio);
        rr_sym_t s;
        if (!active)
            s = SYM_IDLE;
        else if (prio)
            s = SYM_HIGH;
        else
            s = SYM_LOW;
        return s;
    endfunction

endpackage

// File: rtl/rrmx_node.sv
module rrmx_node
    import rrmx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int LEVEL  = 0
) (
    input  rr_sym_t             sym_l,
    input  rr_sym_t             sym_r,
    input  logic [DATA_W-1:0]   data_l,
    input  logic [DATA_W-1:0]   data_r,
    input  logic [IDX_W-1:0]    idx_l,
    input  logic [IDX_W-1:0]    idx_r,
    output rr_sym_t             sym_o,
    output logic [DATA_W-1:0]   data_o,
    output logic [IDX_W-1:0]    idx_o
);

    logic take_left;

    always_comb begin
        // Left wins only on a strictly larger symbol; right wins ties.
        take_left = ~sym_r[0] | (sym_l[1] & ~sym_r[1]);
        sym_o     = sym_l | sym_r;
        data_o    = take_left ? data_l : data_r;
        idx_o     = take_left ? idx_l : idx_r;
        idx_o[LEVEL] = take_left;
    end

endmodule

// File: rtl/rrmx_tree.sv
module rrmx_tree
    import rrmx_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int DATA_W  = 16
) (
    input  rr_sym_t                     sym_in [NUM_REQ],
    input  logic [NUM_REQ*DATA_W-1:0]   data_in,
    output rr_sym_t                     root_sym,
    output logic [DATA_W-1:0]           root_data,
    output logic [$clog2(NUM_REQ)-1:0]  root_idx
);

    localparam int IDX_W  = $clog2(NUM_REQ);
    localparam int LEAVES = 1 << IDX_W;

    rr_sym_t            sym_lv  [IDX_W+1][LEAVES];
    logic [DATA_W-1:0]  data_lv [IDX_W+1][LEAVES];
    logic [IDX_W-1:0]   idx_lv  [IDX_W+1][LEAVES];

    // Leaves: padding positions carry idle symbols.
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < NUM_REQ) begin : g_real
            assign sym_lv[0][j]  = sym_in[j];
            assign data_lv[0][j] = data_in[j*DATA_W +: DATA_W];
        end else begin : g_pad
            assign sym_lv[0][j]  = SYM_IDLE;
            assign data_lv[0][j] = '0;
        end
        assign idx_lv[0][j] = '0;
    end

    for (genvar k = 0; k < IDX_W; k++) begin : g_level
        for (genvar j = 0; j < LEAVES; j++) begin : g_slot
            if (j < (LEAVES >> (k + 1))) begin : g_node
                rrmx_node #(
                    .DATA_W (DATA_W),
                    .IDX_W  (IDX_W),
                    .LEVEL  (k)
                ) node_i (
                    .sym_l  (sym_lv[k][2*j+1]),
                    .sym_r  (sym_lv[k][2*j]),
                    .data_l (data_lv[k][2*j+1]),
                    .data_r (data_lv[k][2*j]),
                    .idx_l  (idx_lv[k][2*j+1]),
                    .idx_r  (idx_lv[k][2*j]),
                    .sym_o  (sym_lv[k+1][j]),
                    .data_o (data_lv[k+1][j]),
                    .idx_o  (idx_lv[k+1][j])
                );
            end else begin : g_empty
                assign sym_lv[k+1][j]  = SYM_IDLE;
                assign data_lv[k+1][j] = '0;
                assign idx_lv[k+1][j]  = '0;
            end
        end
    end

    assign root_sym  = sym_lv[IDX_W][0];
    assign root_data = data_lv[IDX_W][0];
    assign root_idx  = idx_lv[IDX_W][0];

endmodule

// File: rtl/rrmx_prio.sv
module rrmx_prio #(
    parameter int NUM_REQ = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic                        win_valid,
    input  logic [$clog2(NUM_REQ)-1:0]  win_idx,
    output logic [NUM_REQ-1:0]          prio_q
);

    localparam int IDX_W = $clog2(NUM_REQ);

    typedef enum logic {ST_HOLD, ST_ADVANCE} prio_act_e;

    prio_act_e          act;
    logic [NUM_REQ-1:0] prio_n;

    always_comb begin
        act = (upd_en && win_valid) ? ST_ADVANCE : ST_HOLD;
        unique case (act)
            ST_HOLD:    prio_n = prio_q;
            ST_ADVANCE: begin
                if (int'(win_idx) == NUM_REQ - 1) begin
                    prio_n = '1;
                end else begin
                    for (int i = 0; i < NUM_REQ; i++)
                        prio_n[i] = ((IDX_W+1)'(i) > {1'b0, win_idx});
                end
            end
            default:    prio_n = prio_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prio_q <= '1;
        else
            prio_q <= prio_n;
    end

    AST_PRIO_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((prio_q[NUM_REQ-1]) && ((NUM_REQ)'(prio_q << 1) & ~prio_q) == '0)); // R7
    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en && win_valid) |=> $stable(prio_q)); // R8
    AST_PRIO_WINNER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && win_valid && int'(win_idx) != NUM_REQ - 1) |=> !prio_q[$past(win_idx)]); // R7

endmodule

// File: rtl/rrmx_top.sv
module rrmx_top
    import rrmx_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int DATA_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_REQ-1:0]          req,
    input  logic [NUM_REQ*DATA_W-1:0]   data_in,
    input  logic                        upd_en,
    output logic [DATA_W-1:0]           data_out,
    output logic                        any_grant,
    output logic [NUM_REQ-1:0]          gnt_oh,
    output logic [$clog2(NUM_REQ)-1:0]  gnt_idx
);

    localparam int IDX_W = $clog2(NUM_REQ);

    logic [NUM_REQ-1:0] prio_q;
    rr_sym_t            leaf_sym [NUM_REQ];
    rr_sym_t            root_sym;
    logic [DATA_W-1:0]  root_data;
    logic [IDX_W-1:0]   root_idx;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_sym
        assign leaf_sym[i] = make_sym(req[i], prio_q[i]);
    end

    rrmx_tree #(
        .NUM_REQ (NUM_REQ),
        .DATA_W  (DATA_W)
    ) tree_i (
        .sym_in    (leaf_sym),
        .data_in   (data_in),
        .root_sym  (root_sym),
        .root_data (root_data),
        .root_idx  (root_idx)
    );

    rrmx_prio #(
        .NUM_REQ (NUM_REQ)
    ) prio_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .win_valid (any_grant),
        .win_idx   (gnt_idx),
        .prio_q    (prio_q)
    );

    always_comb begin
        any_grant = |root_sym;
        gnt_idx   = any_grant ? root_idx : '0;
        data_out  = any_grant ? root_data : '0;
        gnt_oh    = '0;
        if (any_grant)
            gnt_oh[root_idx] = 1'b1;
    end

    AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        any_grant == (|req)); // R1
    AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh)); // R2
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_oh & ~req) == '0); // R2
    AST_HP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & prio_q)) |-> prio_q[gnt_idx]); // R5

endmodule

// File: tb/rrmx_top_tb_top.sv
module rrmx_top_tb_top;

    localparam int N  = 8;
    localparam int W  = 16;
    localparam int IW = $clog2(N);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       req = '0;
    logic [N*W-1:0]     data_in = '0;
    logic               upd_en = 1'b0;
    logic [W-1:0]       data_out;
    logic               any_grant;
    logic [N-1:0]       gnt_oh;
    logic [IW-1:0]      gnt_idx;

    int checks = 0;
    int fails  = 0;
    int ptr    = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rrmx_top #(.NUM_REQ(N), .DATA_W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .data_in   (data_in),
        .upd_en    (upd_en),
        .data_out  (data_out),
        .any_grant (any_grant),
        .gnt_oh    (gnt_oh),
        .gnt_idx   (gnt_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // One cycle: drive after the edge, compare at the falling edge, advance model.
    task automatic cycle(input logic [N-1:0] r, input logic u, input string tag);
        int win;
        logic [N-1:0] exp_oh;
        req    = r;
        upd_en = u;
        for (int i = 0; i < N; i++) data_in[i*W +: W] = W'($urandom);
        @(negedge clk);
        win = -1;
        for (int k = 0; k < N; k++) begin
            int p;
            p = (ptr + k) % N;
            if (win < 0 && r[p]) win = p;
        end
        exp_oh = '0;
        if (win >= 0) exp_oh[win] = 1'b1;
        chk("R1", 64'(any_grant), 64'(win >= 0));
        chk("R2", 64'(gnt_oh & ~r), 64'(0));
        chk(tag, 64'(gnt_oh), 64'(exp_oh));
        chk("R3", 64'(gnt_idx), (win >= 0) ? 64'(win) : 64'(0));
        chk("R4", 64'(data_out), (win >= 0) ? 64'(data_in[win*W +: W]) : 64'(0));
        if (u && win >= 0) ptr = (win + 1) % N;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // Reset state: no request, nothing granted.
        @(negedge clk);
        chk("R1", 64'(any_grant), 64'(0));
        chk("R4", 64'(data_out), 64'(0));
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R6: position 0 wins first with all requesting.
        cycle('1, 1'b0, "R6");
        cycle(8'b1000_0001, 1'b0, "R6");
        // R7: rotate through every position and wrap.
        for (int i = 0; i < N + 3; i++) cycle('1, 1'b1, "R7");
        cycle(8'b1000_0000, 1'b1, "R7");
        cycle('1, 1'b0, "R7");
        // R8: no update enable, or no request, leaves order unchanged.
        for (int i = 0; i < 4; i++) cycle('1, 1'b0, "R8");
        for (int i = 0; i < 3; i++) cycle('0, 1'b1, "R8");
        cycle('1, 1'b0, "R8");
        cycle(8'b0010_0100, 1'b1, "R8");
        cycle(8'b0010_0100, 1'b0, "R8");
        // R5: long random patterns, dense and sparse.
        for (int i = 0; i < 3000; i++)
            cycle(N'($urandom), 1'($urandom), "R5");
        for (int i = 0; i < 2000; i++)
            cycle(N'($urandom) & N'($urandom) & N'($urandom), 1'($urandom_range(0, 3) != 0), "R5");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(1_000_000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule